// File: doc/BRIEF.md
# Open-Drain Status Pin Generator

This block drives the status pin of a memory device whose program and erase work is done by an internal controller. The pin is open drain, so the block produces only a pull-low enable: when the enable is high the pad sinks current, and when it is low the pad floats and an external resistor pulls it high. The pin is never driven high.

Two reporting modes can be selected while the device runs. In level mode the pin is held low for as long as the controller reports busy. In pulse mode the controller's busy level is ignored. Instead, each end-of-operation event produces a low pulse of a fixed, parameterised number of clock cycles, so that a host can count completions.

A one-bit configure strobe from the command decoder picks the mode. A strobe that arrives while an operation is running is held and applied only when the controller returns to ready. Reset puts the block back into level mode and discards any held request. Reset never pulls the pin low by itself. An operation that the reset aborts cannot leave the pin low: a busy level that is still present when reset ends is masked until the controller first reports ready.

Top module: `sts_pin_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, the pull-low enable is 0.
- R2: In level mode (mode bit 0) the pull-low enable rises one cycle after busy is sampled high and falls one cycle after busy is sampled low.
- R3: In level mode an end-of-operation event has no effect on the pull-low enable.
- R4: In pulse mode (mode bit 1) an end-of-operation event sampled at a clock edge makes the pull-low enable 1 for exactly PULSE_CYCLES cycles, starting right after that edge.
- R5: In pulse mode the busy input has no effect on the pull-low enable.
- R6: An end-of-operation event that arrives during a pulse restarts the pulse, so the enable stays 1 for PULSE_CYCLES cycles after the new event.
- R7: A configure strobe sampled while no operation is running sets the mode from the mode bit at that edge. A switch from pulse mode to level mode ends a running pulse in the next cycle.
- R8: A configure strobe sampled while an operation is running leaves the mode unchanged until busy is sampled low. At that edge the most recent held mode bit is applied.
- R9: Reset returns the block to level mode, ends any pulse and discards a held configure request.
- R10: A busy level that is present when reset ends does not pull the pin low. Busy is honoured again only after it has been sampled low at least once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Controller busy level |
| done_i | input | 1 | One-cycle end-of-operation event |
| cfg_stb_i | input | 1 | Configure command strobe |
| cfg_mode_i | input | 1 | Requested mode: 0 level, 1 pulse |
| sts_pull_low_o | output | 1 | Open-drain pull-low enable for the status pad |

## Verification
The mode bit, the held request and the busy mask have no port of their own. A wrong value in any of them shows only through how the pin reacts to later stimulus. A wrong mode bit shows one cycle after the next busy edge or done event: either the pin follows busy when it should pulse, or it pulses when it should follow busy. A lost or stale held request shows on the first busy or done after the operation ends. An off-by-one pulse counter shows in the exact cycle the pulse ends. For that reason every scenario samples the pin cycle by cycle, right after each event.

// File: rtl/sts_pin_pkg.sv
package sts_pin_pkg;

    typedef enum logic {
        MODE_LEVEL = 1'b0,
        MODE_PULSE = 1'b1
    } sts_mode_e;

    typedef struct packed {
        logic      valid;
        sts_mode_e mode;
    } cfg_req_t;

    function automatic int cnt_bits(input int cycles);
        return (cycles < 1) ? 1 : $clog2(cycles + 1);
    endfunction

endpackage

// File: rtl/sts_busy_qual.sv
module sts_busy_qual (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    output logic busy_eff_o,
    output logic busy_q_o
);
    logic armed_q;

    assign busy_eff_o = busy_i & armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            busy_q_o <= 1'b0;
        end else begin
            if (!busy_i) armed_q <= 1'b1;
            busy_q_o <= busy_eff_o;
        end
    end

    // R10
    stale_busy_masked_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_q |=> !busy_q_o);

endmodule

// File: rtl/sts_mode_ctl.sv
module sts_mode_ctl
    import sts_pin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      busy_eff_i,
    input  logic      cfg_stb_i,
    input  sts_mode_e cfg_mode_i,
    output sts_mode_e mode_o
);
    cfg_req_t pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= MODE_LEVEL;
            pend_q <= '0;
        end else if (!busy_eff_i) begin
            if (cfg_stb_i)         mode_o <= cfg_mode_i;
            else if (pend_q.valid) mode_o <= pend_q.mode;
            pend_q <= '0;
        end else if (cfg_stb_i) begin
            pend_q <= '{valid: 1'b1, mode: cfg_mode_i};
        end
    end

    // R8
    mode_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy_eff_i |=> $stable(mode_o));

    // R7
    mode_apply_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_eff_i && cfg_stb_i) |=> (mode_o == $past(cfg_mode_i)));

endmodule

// File: rtl/sts_pulse_gen.sv
module sts_pulse_gen
    import sts_pin_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic done_i,
    output logic active_o
);
    localparam int CW = cnt_bits(PULSE_CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i)         cnt_q <= '0;
        else if (done_i)          cnt_q <= LOAD;
        else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
    end

    assign active_o = (cnt_q != '0);

    // R4
    pulse_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && !done_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    // R6
    pulse_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (en_i && done_i) |=> (cnt_q == LOAD));

    // R3
    pulse_idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !active_o);

endmodule

// File: rtl/sts_pin_gen.sv
module sts_pin_gen
    import sts_pin_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic done_i,
    input  logic cfg_stb_i,
    input  logic cfg_mode_i,
    output logic sts_pull_low_o
);
    logic      busy_eff;
    logic      busy_q;
    logic      pulse_act;
    sts_mode_e mode_q;

    sts_busy_qual u_qual (
        .clk        (clk),
        .rst        (rst),
        .busy_i     (busy_i),
        .busy_eff_o (busy_eff),
        .busy_q_o   (busy_q)
    );

    sts_mode_ctl u_mode (
        .clk        (clk),
        .rst        (rst),
        .busy_eff_i (busy_eff),
        .cfg_stb_i  (cfg_stb_i),
        .cfg_mode_i (sts_mode_e'(cfg_mode_i)),
        .mode_o     (mode_q)
    );

    sts_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .en_i     (mode_q == MODE_PULSE),
        .done_i   (done_i),
        .active_o (pulse_act)
    );

    always_comb begin
        unique case (mode_q)
            MODE_PULSE: sts_pull_low_o = pulse_act;
            default:    sts_pull_low_o = busy_q;
        endcase
    end

    // R1
    no_pull_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !sts_pull_low_o);

endmodule

// File: tb/sts_pin_gen_tb.sv
module sts_pin_gen_tb_top;

    localparam int P = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic busy = 1'b0;
    logic done = 1'b0;
    logic cfg_stb = 1'b0;
    logic cfg_mode = 1'b0;
    logic pull;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sts_pin_gen #(.PULSE_CYCLES(P)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .busy_i         (busy),
        .done_i         (done),
        .cfg_stb_i      (cfg_stb),
        .cfg_mode_i     (cfg_mode),
        .sts_pull_low_o (pull)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (pull !== exp) begin
            errors++;
            $display("FAIL %s pull_low actual %b expected %b at %0t", tag, pull, exp, $time);
        end
    endtask

    task automatic set_mode(input logic m);
        cfg_stb = 1'b1; cfg_mode = m;
        tick();
        cfg_stb = 1'b0;
    endtask

    task automatic fire_done();
        done = 1'b1;
        tick();
        done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(); tick(); tick();
        chk(1'b0, "R1 during reset");
        rst = 1'b0;
        tick();
        chk(1'b0, "R1 first cycle after reset");
        tick();
    endtask

    task automatic t_level();
        busy = 1'b1; tick();
        chk(1'b1, "R2 busy high");
        tick();
        chk(1'b1, "R2 busy held");
        busy = 1'b0; tick();
        chk(1'b0, "R2 busy low");
    endtask

    task automatic t_level_done();
        fire_done();
        for (int i = 0; i < P + 1; i++) begin
            chk(1'b0, "R3 done ignored in level mode");
            tick();
        end
    endtask

    task automatic t_pulse();
        set_mode(1'b1);
        chk(1'b0, "R7 mode switch alone no pulse");
        fire_done();
        for (int i = 0; i < P; i++) begin
            chk(1'b1, "R4 pulse low");
            tick();
        end
        chk(1'b0, "R4 pulse ended");
    endtask

    task automatic t_pulse_busy();
        busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(1'b0, "R5 busy ignored in pulse mode");
        end
        busy = 1'b0; tick();
        chk(1'b0, "R5 busy release in pulse mode");
    endtask

    task automatic t_retrigger();
        fire_done();
        chk(1'b1, "R6 first pulse");
        tick();
        chk(1'b1, "R6 first pulse 2");
        fire_done();
        for (int i = 0; i < P; i++) begin
            chk(1'b1, "R6 restarted pulse");
            tick();
        end
        chk(1'b0, "R6 restarted pulse ended");
    endtask

    task automatic t_defer();
        busy = 1'b1; tick();
        set_mode(1'b0);
        tick();
        chk(1'b0, "R8 still pulse mode while busy");
        fire_done();
        chk(1'b1, "R8 pulse while deferred");
        for (int i = 0; i < P; i++) tick();
        chk(1'b0, "R8 pulse over");
        busy = 1'b0; tick();
        chk(1'b0, "R8 ready edge");
        busy = 1'b1; tick();
        chk(1'b1, "R8 level mode applied after ready");
        busy = 1'b0; tick();
        chk(1'b0, "R8 level release");
        busy = 1'b1; tick();
        set_mode(1'b1);
        set_mode(1'b0);
        chk(1'b1, "R8 level held while busy");
        busy = 1'b0; tick();
        fire_done();
        chk(1'b0, "R8 latest held request wins");
        tick();
        chk(1'b0, "R8 latest held request wins 2");
    endtask

    task automatic t_cut();
        set_mode(1'b1);
        fire_done();
        chk(1'b1, "R7 pulse running");
        set_mode(1'b0);
        chk(1'b0, "R7 switch to level ends pulse");
    endtask

    task automatic t_reset_mid();
        set_mode(1'b1);
        fire_done();
        chk(1'b1, "R9 pulse before reset");
        rst = 1'b1; tick();
        chk(1'b0, "R9 reset ends pulse");
        rst = 1'b0; tick(); tick();
        fire_done();
        chk(1'b0, "R9 level mode after reset");
        busy = 1'b1; tick();
        set_mode(1'b1);
        rst = 1'b1; busy = 1'b0; tick(); tick();
        rst = 1'b0; tick(); tick();
        fire_done();
        chk(1'b0, "R9 held request discarded");
    endtask

    task automatic t_reset_abort();
        busy = 1'b1; tick();
        chk(1'b1, "R10 busy before reset");
        rst = 1'b1; tick();
        chk(1'b0, "R10 reset releases pin");
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(1'b0, "R10 stale busy masked");
        end
        busy = 1'b0; tick();
        chk(1'b0, "R10 ready seen");
        busy = 1'b1; tick();
        chk(1'b1, "R10 busy honoured again");
        busy = 1'b0; tick();
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        t_level();
        t_level_done();
        t_pulse();
        t_pulse_busy();
        t_retrigger();
        t_defer();
        t_cut();
        t_reset_mid();
        t_reset_abort();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule